// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Unit

This block is the hazard and bypass control of a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback). Each cycle it looks at the source register numbers of the instructions in decode and in execute, the destination numbers and write enables held in the two pipeline registers after execute, a load flag for the instruction in execute, and a branch-taken signal that decode resolves. From these it picks the operand source for each ALU input, chooses whether each decode read should take the value being written back in the same cycle, and decides when the front of the pipe must hold, when execute must receive a no-op, and when the instruction just fetched must be discarded.

The block is purely combinational. The register file, ALU, memories and pipeline registers sit outside it and consume its outputs. A parameter picks the branch policy at build time: predict-not-taken with a flush of the one wrong-path instruction, or a single delay slot whose instruction always runs. Branches resolve in decode, so at most one instruction is ever on the wrong path. A result written back is visible to the ALU three cycles after the instruction leaves execute, which is why the two bypass levels exist.

Top module: `hazard_fwd_unit`

## Requirements
- R1: When an ALU source in execute equals the EX/MEM destination, that destination is nonzero and the EX/MEM write enable is high, the select for that input is 2'b10.
- R2: When an ALU source in execute equals the nonzero MEM/WB destination with its write enable high, and R1 does not apply, the select is 2'b01; with neither match the select is 2'b00. The code 2'b11 never appears.
- R3: When both EX/MEM and MEM/WB match the same source, the select is 2'b10 (the younger result wins).
- R4: Register number 0 never causes a bypass, a write-through or a load-use stall; with every input at zero all outputs are zero.
- R5: A decode source equal to the nonzero MEM/WB destination with its write enable high raises that source's write-through flag (id_wt_a or id_wt_b), so the read returns the value being written.
- R6: When the instruction in execute is a load whose nonzero destination equals either decode source, stall and bubble are both high for that cycle, unless R10 applies; otherwise both are low.
- R7: While bubble is high, nx_we, nx_mem_rd and nx_mem_wr are 0; otherwise they equal id_we, id_mem_rd and id_mem_wr.
- R8: With DELAY_SLOT = 0, flush equals id_branch_taken.
- R9: With DELAY_SLOT = 1, flush stays 0 whatever the branch outcome, so the instruction after a branch always executes.
- R10: When flush is high, stall and bubble are low in the same cycle.
- R11: A destination match with its write enable low causes no bypass and no write-through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_src_a | input | REG_AW | First source register of the instruction in decode |
| id_src_b | input | REG_AW | Second source register of the instruction in decode |
| id_branch_taken | input | 1 | Branch in decode resolved as taken |
| id_we | input | 1 | Register write enable decoded for the decode instruction |
| id_mem_rd | input | 1 | Memory read control decoded for the decode instruction |
| id_mem_wr | input | 1 | Memory write control decoded for the decode instruction |
| ex_src_a | input | REG_AW | First ALU source register of the instruction in execute |
| ex_src_b | input | REG_AW | Second ALU source register of the instruction in execute |
| ex_dst | input | REG_AW | Destination register of the instruction in execute |
| ex_is_load | input | 1 | Instruction in execute is a load |
| mem_dst | input | REG_AW | Destination held in the EX/MEM register |
| mem_we | input | 1 | Write enable held in the EX/MEM register |
| wb_dst | input | REG_AW | Destination held in the MEM/WB register |
| wb_we | input | 1 | Write enable held in the MEM/WB register |
| fwd_a | output | 2 | Select for ALU input A: 00 register file, 01 MEM/WB, 10 EX/MEM |
| fwd_b | output | 2 | Select for ALU input B, same coding |
| id_wt_a | output | 1 | Decode read A takes the writeback value |
| id_wt_b | output | 1 | Decode read B takes the writeback value |
| stall | output | 1 | Hold the program counter and the IF/ID register |
| bubble | output | 1 | Load a no-op into ID/EX |
| flush | output | 1 | Discard the instruction in IF/ID |
| nx_we | output | 1 | Register write enable entering ID/EX |
| nx_mem_rd | output | 1 | Memory read control entering ID/EX |
| nx_mem_wr | output | 1 | Memory write control entering ID/EX |

## Verification
The two functions that can coincide are the load-use hold and the branch flush: a taken branch sitting in decode can depend on a load in execute in the very same cycle. The sweep provokes this by running every combination of load flag, load destination, both decode sources and branch outcome against one build of each branch policy, and judges that in the not-taken build the flush alone is raised while stall and bubble drop, and in the delay-slot build the stall is kept with no flush. The same sweep checks that the controls handed to execute are cleared exactly in the cycles where the bubble is raised.

// File: rtl/hazard_fwd_unit.sv
module hazard_fwd_unit #(
  parameter int REG_AW     = 5,
  parameter bit DELAY_SLOT = 1'b0
) (
  input  logic [REG_AW-1:0] id_src_a,
  input  logic [REG_AW-1:0] id_src_b,
  input  logic              id_branch_taken,
  input  logic              id_we,
  input  logic              id_mem_rd,
  input  logic              id_mem_wr,
  input  logic [REG_AW-1:0] ex_src_a,
  input  logic [REG_AW-1:0] ex_src_b,
  input  logic [REG_AW-1:0] ex_dst,
  input  logic              ex_is_load,
  input  logic [REG_AW-1:0] mem_dst,
  input  logic              mem_we,
  input  logic [REG_AW-1:0] wb_dst,
  input  logic              wb_we,
  output logic [1:0]        fwd_a,
  output logic [1:0]        fwd_b,
  output logic              id_wt_a,
  output logic              id_wt_b,
  output logic              stall,
  output logic              bubble,
  output logic              flush,
  output logic              nx_we,
  output logic              nx_mem_rd,
  output logic              nx_mem_wr
);

  localparam logic [1:0] SEL_RF  = 2'b00;
  localparam logic [1:0] SEL_WB  = 2'b01;
  localparam logic [1:0] SEL_MEM = 2'b10;

  logic mem_live, wb_live, ld_live, load_use;

  assign mem_live = mem_we && (mem_dst != '0);
  assign wb_live  = wb_we  && (wb_dst  != '0);
  assign ld_live  = ex_is_load && (ex_dst != '0);

  function automatic logic [1:0] pick(input logic [REG_AW-1:0] src);
    if (mem_live && (mem_dst == src))     return SEL_MEM;
    else if (wb_live && (wb_dst == src))  return SEL_WB;
    else                                  return SEL_RF;
  endfunction

  assign fwd_a = pick(ex_src_a);
  assign fwd_b = pick(ex_src_b);

  assign id_wt_a = wb_live && (wb_dst == id_src_a);
  assign id_wt_b = wb_live && (wb_dst == id_src_b);

  assign load_use = ld_live && ((ex_dst == id_src_a) || (ex_dst == id_src_b));

  generate
    if (DELAY_SLOT) begin : g_slot
      assign flush = 1'b0;
    end else begin : g_pnt
      assign flush = id_branch_taken;
    end
  endgenerate

  assign stall  = load_use && !flush;
  assign bubble = stall;

  assign nx_we     = id_we     && !bubble;
  assign nx_mem_rd = id_mem_rd && !bubble;
  assign nx_mem_wr = id_mem_wr && !bubble;

endmodule

// File: rtl/hazard_fwd_chk.sv
module hazard_fwd_chk #(
  parameter int REG_AW     = 5,
  parameter bit DELAY_SLOT = 1'b0
) (
  input logic [REG_AW-1:0] id_src_a,
  input logic [REG_AW-1:0] id_src_b,
  input logic [REG_AW-1:0] ex_src_a,
  input logic [REG_AW-1:0] ex_src_b,
  input logic [1:0]        fwd_a,
  input logic [1:0]        fwd_b,
  input logic              id_wt_a,
  input logic              id_wt_b,
  input logic              stall,
  input logic              bubble,
  input logic              flush,
  input logic              nx_we,
  input logic              nx_mem_rd,
  input logic              nx_mem_wr
);

  logic known;
  assign known = !$isunknown({id_src_a, id_src_b, ex_src_a, ex_src_b, fwd_a, fwd_b,
                              id_wt_a, id_wt_b, stall, bubble, flush,
                              nx_we, nx_mem_rd, nx_mem_wr});

  always_comb begin
    if (known) begin
      a_r2_no_code3: assert (fwd_a != 2'b11 && fwd_b != 2'b11)
        else $error("R2: reserved select code");
      a_r4_zero_fwd: assert ((ex_src_a != '0 || fwd_a == 2'b00) && (ex_src_b != '0 || fwd_b == 2'b00))
        else $error("R4: bypass on register 0");
      a_r4_zero_wt: assert ((id_src_a != '0 || !id_wt_a) && (id_src_b != '0 || !id_wt_b))
        else $error("R4: write-through on register 0");
      a_r6_pair: assert (stall == bubble)
        else $error("R6: stall and bubble disagree");
      a_r7_kill: assert (!bubble || (!nx_we && !nx_mem_rd && !nx_mem_wr))
        else $error("R7: bubble leaves controls live");
      a_r9_slot: assert (!DELAY_SLOT || !flush)
        else $error("R9: flush in delay-slot build");
      a_r10_prio: assert (!flush || (!stall && !bubble))
        else $error("R10: stall alongside flush");
    end
  end

endmodule

bind hazard_fwd_unit hazard_fwd_chk #(.REG_AW(REG_AW), .DELAY_SLOT(DELAY_SLOT)) u_chk (
  .id_src_a(id_src_a), .id_src_b(id_src_b), .ex_src_a(ex_src_a), .ex_src_b(ex_src_b),
  .fwd_a(fwd_a), .fwd_b(fwd_b), .id_wt_a(id_wt_a), .id_wt_b(id_wt_b),
  .stall(stall), .bubble(bubble), .flush(flush),
  .nx_we(nx_we), .nx_mem_rd(nx_mem_rd), .nx_mem_wr(nx_mem_wr)
);

// File: tb/sim_hazard_fwd_unit.sv
module sim_hazard_fwd_unit;
  localparam int CLK_P = 10;
  localparam int AW    = 3;
  localparam int NREG  = 1 << AW;

  logic clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic [AW-1:0] id_src_a = '0, id_src_b = '0, ex_src_a = '0, ex_src_b = '0;
  logic [AW-1:0] ex_dst = '0, mem_dst = '0, wb_dst = '0;
  logic id_branch_taken = 0, id_we = 0, id_mem_rd = 0, id_mem_wr = 0;
  logic ex_is_load = 0, mem_we = 0, wb_we = 0;

  logic [1:0] fa0, fb0, fa1, fb1;
  logic wa0, wb0, st0, bu0, fl0, nw0, nr0, nm0;
  logic wa1, wb1, st1, bu1, fl1, nw1, nr1, nm1;

  hazard_fwd_unit #(.REG_AW(AW), .DELAY_SLOT(1'b0)) u0 (
    .id_src_a, .id_src_b, .id_branch_taken, .id_we, .id_mem_rd, .id_mem_wr,
    .ex_src_a, .ex_src_b, .ex_dst, .ex_is_load, .mem_dst, .mem_we, .wb_dst, .wb_we,
    .fwd_a(fa0), .fwd_b(fb0), .id_wt_a(wa0), .id_wt_b(wb0), .stall(st0), .bubble(bu0),
    .flush(fl0), .nx_we(nw0), .nx_mem_rd(nr0), .nx_mem_wr(nm0));

  hazard_fwd_unit #(.REG_AW(AW), .DELAY_SLOT(1'b1)) u1 (
    .id_src_a, .id_src_b, .id_branch_taken, .id_we, .id_mem_rd, .id_mem_wr,
    .ex_src_a, .ex_src_b, .ex_dst, .ex_is_load, .mem_dst, .mem_we, .wb_dst, .wb_we,
    .fwd_a(fa1), .fwd_b(fb1), .id_wt_a(wa1), .id_wt_b(wb1), .stall(st1), .bubble(bu1),
    .flush(fl1), .nx_we(nw1), .nx_mem_rd(nr1), .nx_mem_wr(nm1));

  int total = 0, bad = 0;
  bit done = 0;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_sel(int src, int md, int mw, int wd, int ww);
    if (src != 0 && mw == 1 && md == src) return 2;
    if (src != 0 && ww == 1 && wd == src) return 1;
    return 0;
  endfunction

  function automatic string sel_tag(int src, int md, int mw, int wd, int ww);
    if (src == 0) return "R4";
    if (md == src && mw == 1 && wd == src && ww == 1) return "R3";
    if (md == src && mw == 1) return "R1";
    if ((md == src && mw == 0) || (wd == src && ww == 0)) return "R11";
    return "R2";
  endfunction

  initial begin
    @(negedge clk);
    #1;
    chk("R4 idle fwd_a", fa0, 0);
    chk("R4 idle fwd_b", fb0, 0);
    chk("R4 idle stall", st0, 0);
    chk("R4 idle flush", fl0, 0);
    chk("R4 idle wt", {wa0, wb0}, 0);

    for (int sa = 0; sa < NREG; sa++)
      for (int md = 0; md < NREG; md++)
        for (int wd = 0; wd < NREG; wd++)
          for (int mw = 0; mw < 2; mw++)
            for (int ww = 0; ww < 2; ww++) begin
              int sb;
              sb = sa ^ 3;
              ex_src_a = AW'(sa); ex_src_b = AW'(sb);
              mem_dst = AW'(md); wb_dst = AW'(wd);
              mem_we = mw[0]; wb_we = ww[0];
              #1;
              chk({sel_tag(sa, md, mw, wd, ww), " fwd_a"}, fa0, exp_sel(sa, md, mw, wd, ww));
              chk({sel_tag(sb, md, mw, wd, ww), " fwd_b"}, fb0, exp_sel(sb, md, mw, wd, ww));
              chk({sel_tag(sa, md, mw, wd, ww), " fwd_a slot build"}, fa1, exp_sel(sa, md, mw, wd, ww));
            end
    mem_we = 0;

    for (int a = 0; a < NREG; a++)
      for (int b = 0; b < NREG; b++)
        for (int wd = 0; wd < NREG; wd++)
          for (int ww = 0; ww < 2; ww++) begin
            id_src_a = AW'(a); id_src_b = AW'(b); wb_dst = AW'(wd); wb_we = ww[0];
            #1;
            chk((a == 0) ? "R4 wt_a" : (ww == 0) ? "R11 wt_a" : "R5 wt_a",
                wa0, (a != 0 && ww == 1 && wd == a) ? 1 : 0);
            chk((b == 0) ? "R4 wt_b" : (ww == 0) ? "R11 wt_b" : "R5 wt_b",
                wb0, (b != 0 && ww == 1 && wd == b) ? 1 : 0);
          end
    wb_we = 0;

    for (int a = 0; a < NREG; a++)
      for (int b = 0; b < NREG; b++)
        for (int d = 0; d < NREG; d++)
          for (int ld = 0; ld < 2; ld++)
            for (int br = 0; br < 2; br++) begin
              int haz, ctl, ctl_b;
              ctl = (a + b + d) % 8;
              id_src_a = AW'(a); id_src_b = AW'(b); ex_dst = AW'(d);
              ex_is_load = ld[0]; id_branch_taken = br[0];
              {id_we, id_mem_rd, id_mem_wr} = 3'(ctl);
              haz = (ld == 1 && d != 0 && (d == a || d == b)) ? 1 : 0;
              #1;
              chk("R8 flush pnt", fl0, br);
              chk("R9 flush slot", fl1, 0);
              chk((br == 1 && haz == 1) ? "R10 stall pnt" : (d == 0) ? "R4 stall pnt" : "R6 stall pnt",
                  st0, (haz == 1 && br == 0) ? 1 : 0);
              chk((br == 1 && haz == 1) ? "R10 bubble pnt" : "R6 bubble pnt",
                  bu0, (haz == 1 && br == 0) ? 1 : 0);
              chk("R6 stall slot", st1, haz);
              chk("R6 bubble slot", bu1, haz);
              ctl_b = (haz == 1 && br == 0) ? 0 : ctl;
              chk("R7 ctl pnt", {nw0, nr0, nm0}, ctl_b);
              chk("R7 ctl slot", {nw1, nr1, nm1}, (haz == 1) ? 0 : ctl);
            end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule